// File: doc/BRIEF.md
# Keyboard Matrix Row Scanner

This block scans a key matrix of up to 16 rows by 8 columns. While enabled it runs a repeating pass: a fixed start wait, then each active row in turn is pulled low for a dwell of a fixed settle time plus a programmable debounce window, then a programmable gap. The column lines are read as pressed when low. A key counts as pressed only if its column held the same level for the whole debounce window of its row.

At the end of each pass the block publishes a snapshot of up to eight pressed keys, one byte each, on a one-cycle strobe. Alongside the snapshot it updates a wake flag. The flag is driven only by keys whose bit in a per-row mask word is clear. A host-side FIFO or interrupt logic takes the strobe and the entries. Pin multiplexing and register access live outside this block.

Top module: `keymatrix_scanner`

## Requirements
- R1: Exactly one row line is low while a row is scanned and all others are high. The rows are visited in order 0 to N-1, where N is `active_rows` clamped into 1..16 (0 reads as 1). No row at or above N is ever driven.
- R2: Every pass starts with a 5-cycle wait in which no row is driven. Row 0 goes low `repeat_dly` + 5 cycles after the cycle in which `snap_valid` is high. After `enable` rises, row 0 goes low in the 6th cycle.
- R3: Each row stays low for 16 + D cycles, where D is the effective debounce count.
- R4: D equals `debounce_req` when that is below 0x3FF, and 0x3FF otherwise.
- R5: A key is pressed when its column reads low while its row is driven. The column is sampled at the end of the 16-cycle settle time. The key is accepted only if the column keeps that same level in every one of the following D cycles of the dwell.
- R6: Each entry is one byte: bit 7 valid, bits 6:3 row index, bits 2:0 column index. Slot i of `snap_entries` occupies bits 8i+7:8i.
- R7: Accepted keys fill the slots in row-major scan order (lower row first, then lower column), up to 8 keys per pass. Any further keys are dropped. Unused slots read 0x00.
- R8: `snap_valid` is high for exactly one cycle after the last active row's dwell. Consecutive strobes are 5 + N*(16+D) + `repeat_dly` cycles apart.
- R9: `wake` changes only together with a snapshot. It is 1 exactly when some key accepted in that pass has its bit clear in `wake_mask`, at bit index row*8 + column (the linear scan code). A mask row of all ones blocks every key in that row.
- R10: While `enable` is low, or in reset, all rows are high, `snap_valid` and `wake` are 0, and the pass restarts from the start wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the scan |
| debounce_req | input | 12 | Requested debounce cycles (saturates at 0x3FF) |
| repeat_dly | input | 16 | Gap cycles after each pass |
| active_rows | input | 5 | Number of rows to scan |
| wake_mask | input | 128 | Per-key wake block bits, index row*8+column |
| col_in | input | 8 | Raw column lines, low = pressed |
| row_drive | output | 16 | Row lines, active low |
| snap_valid | output | 1 | One-cycle snapshot strobe |
| snap_entries | output | 64 | Eight entry bytes |
| wake | output | 1 | A wake-enabled key was seen in the last pass |

## Verification
The debounce decision for the last active row and the publication of the snapshot and wake flag fall on the same clock edge. A key in that row must reach both the entries and the wake flag without slipping a pass. The bench provokes this by pressing keys in row N-1 (row 15 with all rows active, row 3 with four rows), with the mask bit opened or closed. It judges the result at the strobe cycle against entries and a wake value computed from the pressed set. A second coincidence, a row's dwell ending while a chattering column is still moving, is driven by a column that toggles every cycle. That key must never be reported.

// File: rtl/kms_pkg.sv
package kms_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_ROW, PH_GAP} phase_t;

  function automatic int unsigned sat_debounce(input int unsigned req, input int unsigned limit);
    return (req > limit) ? limit : req;
  endfunction

  function automatic int unsigned clamp_rows(input int unsigned req, input int unsigned limit);
    if (req == 0) return 1;
    if (req > limit) return limit;
    return req;
  endfunction
endpackage

// File: rtl/kms_seq.sv
module kms_seq #(
  parameter int ROWS       = 16,
  parameter int START_WAIT = 5,
  parameter int SETTLE     = 16,
  parameter int DBW        = 10,
  parameter int RPTW       = 16,
  localparam int RW        = $clog2(ROWS),
  localparam int TW        = ((DBW > RPTW) ? DBW : RPTW) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DBW-1:0]   deb_eff,
  input  logic [RPTW-1:0]  rpt,
  input  logic [RW:0]      nrows_eff,
  output kms_pkg::phase_t  phase,
  output logic [RW-1:0]    row_idx,
  output logic [TW-1:0]    cnt,
  output logic             row_end,
  output logic             pass_end
);
  import kms_pkg::*;

  logic [TW-1:0] dwell_last;
  assign dwell_last = TW'(SETTLE - 1) + TW'(deb_eff);
  assign row_end    = (phase == PH_ROW) && (cnt == dwell_last);
  assign pass_end   = row_end && (row_idx == RW'(nrows_eff - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; cnt <= '0; row_idx <= '0;
    end else if (!enable) begin
      phase <= PH_IDLE; cnt <= '0; row_idx <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin phase <= PH_START; cnt <= '0; end
        PH_START:
          if (cnt == TW'(START_WAIT - 1)) begin
            phase <= PH_ROW; cnt <= '0; row_idx <= '0;
          end else cnt <= cnt + 1'b1;
        PH_ROW:
          if (row_end) begin
            cnt <= '0;
            if (pass_end) begin
              row_idx <= '0;
              phase   <= (rpt == '0) ? PH_START : PH_GAP;
            end else row_idx <= row_idx + 1'b1;
          end else cnt <= cnt + 1'b1;
        default:
          if (cnt == TW'(rpt) - 1'b1) begin
            phase <= PH_START; cnt <= '0;
          end else cnt <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/kms_debounce.sv
module kms_debounce #(
  parameter int COLS   = 8,
  parameter int SETTLE = 16,
  parameter int TW     = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_row,
  input  logic [TW-1:0]   cnt,
  input  logic [COLS-1:0] pressed,
  output logic [COLS-1:0] hits
);
  logic [COLS-1:0] ref_q, stab_q, cur_ref, cur_stab;
  logic at_ref, in_window;

  assign at_ref    = in_row && (cnt == TW'(SETTLE - 1));
  assign in_window = in_row && (cnt >= TW'(SETTLE - 1));
  assign cur_ref   = at_ref ? pressed : ref_q;
  assign cur_stab  = at_ref ? '1 : (stab_q & ~(ref_q ^ pressed));
  assign hits      = cur_ref & cur_stab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0; stab_q <= '0;
    end else if (in_window) begin
      ref_q <= cur_ref; stab_q <= cur_stab;
    end
  end
endmodule

// File: rtl/kms_collect.sv
module kms_collect #(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int SLOTS = 8,
  localparam int RW   = $clog2(ROWS),
  localparam int CNTW = $clog2(SLOTS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  row_end,
  input  logic                  pass_end,
  input  logic [RW-1:0]         row_idx,
  input  logic [COLS-1:0]       hits,
  input  logic [COLS-1:0]       row_mask,
  output logic                  snap_valid,
  output logic [SLOTS*8-1:0]    snap_entries,
  output logic                  wake,
  output logic                  wake_hit
);
  logic [SLOTS-1:0][7:0] acc_q, nxt, snap_q;
  logic [CNTW-1:0]       cnt_q, cnt_n;
  logic                  wake_acc;

  assign wake_hit     = |(hits & ~row_mask);
  assign snap_entries = snap_q;

  always_comb begin
    int k;
    nxt = acc_q;
    k   = int'(cnt_q);
    for (int c = 0; c < COLS; c++) begin
      if (hits[c] && k < SLOTS) begin
        nxt[k] = {1'b1, 4'(row_idx), 3'(c)};
        k++;
      end
    end
    cnt_n = CNTW'(k);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; cnt_q <= '0; wake_acc <= 1'b0;
      snap_q <= '0; snap_valid <= 1'b0; wake <= 1'b0;
    end else if (!enable) begin
      acc_q <= '0; cnt_q <= '0; wake_acc <= 1'b0;
      snap_q <= '0; snap_valid <= 1'b0; wake <= 1'b0;
    end else begin
      snap_valid <= 1'b0;
      if (pass_end) begin
        snap_q     <= nxt;
        snap_valid <= 1'b1;
        wake       <= wake_acc | wake_hit;
        acc_q      <= '0;
        cnt_q      <= '0;
        wake_acc   <= 1'b0;
      end else if (row_end) begin
        acc_q    <= nxt;
        cnt_q    <= cnt_n;
        wake_acc <= wake_acc | wake_hit;
      end
    end
  end
endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner #(
  parameter int ROWS       = 16,
  parameter int COLS       = 8,
  parameter int SLOTS      = 8,
  parameter int START_WAIT = 5,
  parameter int SETTLE     = 16,
  parameter int DREQW      = 12,
  parameter int DBW        = 10,
  parameter int RPTW       = 16,
  localparam int RW        = $clog2(ROWS),
  localparam int TW        = ((DBW > RPTW) ? DBW : RPTW) + 1,
  localparam int DEB_MAX   = (1 << DBW) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic [DREQW-1:0]      debounce_req,
  input  logic [RPTW-1:0]       repeat_dly,
  input  logic [RW:0]           active_rows,
  input  logic [ROWS*COLS-1:0]  wake_mask,
  input  logic [COLS-1:0]       col_in,
  output logic [ROWS-1:0]       row_drive,
  output logic                  snap_valid,
  output logic [SLOTS*8-1:0]    snap_entries,
  output logic                  wake
);
  import kms_pkg::*;

  logic [DBW-1:0]  deb_eff;
  logic [RW:0]     nrows_eff;
  phase_t          phase;
  logic [RW-1:0]   row_idx;
  logic [TW-1:0]   cnt;
  logic            row_end, pass_end, wake_hit;
  logic [COLS-1:0] hits, row_mask;

  assign deb_eff   = DBW'(sat_debounce(32'(debounce_req), DEB_MAX));
  assign nrows_eff = (RW+1)'(clamp_rows(32'(active_rows), ROWS));
  assign row_mask  = wake_mask[int'(row_idx)*COLS +: COLS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_drive[r] = ~((phase == PH_ROW) && (row_idx == RW'(r)));
  end

  kms_seq #(.ROWS(ROWS), .START_WAIT(START_WAIT), .SETTLE(SETTLE), .DBW(DBW), .RPTW(RPTW)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .deb_eff(deb_eff), .rpt(repeat_dly),
    .nrows_eff(nrows_eff), .phase(phase), .row_idx(row_idx), .cnt(cnt),
    .row_end(row_end), .pass_end(pass_end));

  kms_debounce #(.COLS(COLS), .SETTLE(SETTLE), .TW(TW)) u_deb (
    .clk(clk), .rst_n(rst_n), .in_row(phase == PH_ROW), .cnt(cnt),
    .pressed(~col_in), .hits(hits));

  kms_collect #(.ROWS(ROWS), .COLS(COLS), .SLOTS(SLOTS)) u_col (
    .clk(clk), .rst_n(rst_n), .enable(enable), .row_end(row_end), .pass_end(pass_end),
    .row_idx(row_idx), .hits(hits), .row_mask(row_mask), .snap_valid(snap_valid),
    .snap_entries(snap_entries), .wake(wake), .wake_hit(wake_hit));
endmodule

// File: rtl/keymatrix_scanner_chk.sv
module keymatrix_scanner_chk #(
  parameter int ROWS  = 16,
  parameter int SLOTS = 8,
  localparam int RW   = $clog2(ROWS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic [ROWS-1:0]     row_drive,
  input logic                snap_valid,
  input logic [SLOTS*8-1:0]  snap_entries,
  input logic                wake,
  input kms_pkg::phase_t     phase,
  input logic [RW-1:0]       row_idx,
  input logic [RW:0]         nrows_eff,
  input logic                pass_end
);
  logic pad_ok;
  always_comb begin
    logic gone;
    gone   = 1'b0;
    pad_ok = 1'b1;
    for (int i = 0; i < SLOTS; i++) begin
      if (gone && snap_entries[i*8 +: 8] != 8'h00) pad_ok = 1'b0;
      if (!snap_entries[i*8+7]) begin
        gone = 1'b1;
        if (snap_entries[i*8 +: 8] != 8'h00) pad_ok = 1'b0;
      end
    end
  end

  AST_ONE_ROW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_drive) <= 1); // R1
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == kms_pkg::PH_ROW) |-> ({1'b0, row_idx} < nrows_eff)); // R1
  AST_SNAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |=> !snap_valid); // R8
  AST_SNAP_AFTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> $past(pass_end)); // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (&row_drive && !snap_valid && !wake)); // R10
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    snap_valid |-> pad_ok); // R7
  AST_WAKE_WITH_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !snap_valid) |-> $stable(wake)); // R9
endmodule

bind keymatrix_scanner keymatrix_scanner_chk #(.ROWS(ROWS), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .row_drive(row_drive),
  .snap_valid(snap_valid), .snap_entries(snap_entries), .wake(wake),
  .phase(phase), .row_idx(row_idx), .nrows_eff(nrows_eff), .pass_end(pass_end));

// File: tb/keymatrix_scanner_test.sv
module keymatrix_scanner_test;
  logic         clk = 1'b0;
  logic         rst_n, enable;
  logic [11:0]  deb_req;
  logic [15:0]  rpt;
  logic [4:0]   nrows;
  logic [127:0] wmask;
  logic [7:0]   col_in;
  logic [15:0]  row_drive;
  logic         snap_valid, wake;
  logic [63:0]  snap_entries;

  logic [15:0][7:0] keys;
  logic chat_en, chat_ph;
  int   chr, chc;
  int   n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  keymatrix_scanner uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .debounce_req(deb_req),
    .repeat_dly(rpt), .active_rows(nrows), .wake_mask(wmask), .col_in(col_in),
    .row_drive(row_drive), .snap_valid(snap_valid), .snap_entries(snap_entries), .wake(wake));

  initial chat_ph = 1'b0;
  always @(negedge clk) chat_ph <= ~chat_ph;

  always_comb begin
    col_in = '1;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 8; c++)
        if (!row_drive[r] && (keys[r][c] || (chat_en && r == chr && c == chc && chat_ph)))
          col_in[c] = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_rows(input int req);
    return (req == 0) ? 1 : ((req > 16) ? 16 : req);
  endfunction

  function automatic int eff_deb(input int req);
    return (req > 1023) ? 1023 : req;
  endfunction

  function automatic logic [63:0] exp_snap(input int n);
    logic [63:0] v = '0;
    int k = 0;
    for (int r = 0; r < n; r++)
      for (int c = 0; c < 8; c++)
        if (keys[r][c] && k < 8) begin
          v[k*8 +: 8] = 8'h80 | 8'(r << 3) | 8'(c);
          k++;
        end
    return v;
  endfunction

  function automatic bit exp_wake(input int n);
    bit w = 1'b0;
    for (int r = 0; r < n; r++)
      for (int c = 0; c < 8; c++)
        if (keys[r][c] && !wmask[r*8 + c]) w = 1'b1;
    return w;
  endfunction

  task automatic wait_snap();
    int g = 0;
    while (g < 30000) begin
      @(negedge clk);
      g++;
      if (snap_valid) break;
    end
  endtask

  task automatic measure(input int n, input int d, input int gap);
    int k = 0, first_low = -1, run = 0, next_row = 0, prev = -1;
    bit order_ok = 1'b1, multi = 1'b0;
    while (k < 30000) begin
      @(negedge clk);
      k++;
      if (snap_valid) break;
      if (row_drive != 16'hFFFF) begin
        int idx = 0;
        if ($countones(~row_drive) != 1) multi = 1'b1;
        for (int r = 0; r < 16; r++) if (!row_drive[r]) idx = r;
        if (idx != prev) begin
          if (idx != next_row) order_ok = 1'b0;
          next_row++;
        end
        prev = idx;
        if (idx == 0) begin
          if (first_low < 0) first_low = k;
          run++;
        end
      end else prev = -1;
    end
    chk(first_low == gap + 5, "R2 start wait after strobe", 64'(first_low), 64'(gap + 5));
    chk(run == 16 + d, "R3 row dwell length", 64'(run), 64'(16 + d));
    chk(k == 5 + n*(16 + d) + gap, "R8 strobe period", 64'(k), 64'(5 + n*(16 + d) + gap));
    chk(order_ok && !multi && next_row == n, "R1 row order and count", 64'(next_row), 64'(n));
    chk(snap_entries == exp_snap(n), "R6 R7 snapshot entries", snap_entries, exp_snap(n));
    chk(wake == exp_wake(n), "R9 wake flag", 64'(wake), 64'(exp_wake(n)));
  endtask

  task automatic run_cfg(input int n_req, input int d_req, input int gap);
    @(negedge clk); enable = 1'b0;
    repeat (2) @(negedge clk);
    nrows = 5'(n_req); deb_req = 12'(d_req); rpt = 16'(gap); enable = 1'b1;
    wait_snap();
    measure(eff_rows(n_req), eff_deb(d_req), gap);
  endtask

  initial begin
    #(8*190000);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int rows_set[3] = '{1, 3, 16};
    int debs[3] = '{0, 2, 5};
    int gaps[2] = '{0, 3};
    bit quiet;
    int wait_n;
    rst_n = 1'b0; enable = 1'b0; deb_req = '0; rpt = '0; nrows = 5'd1;
    wmask = '1; keys = '0; chat_en = 1'b0; chr = 0; chc = 0;
    repeat (4) @(negedge clk);
    chk(&row_drive && !snap_valid && !wake, "R10 reset state", {row_drive, 6'b0, snap_valid, wake}, 64'hFFFF << 8);
    rst_n = 1'b1;
    quiet = 1'b1;
    repeat (60) begin @(negedge clk); if (!(&row_drive) || snap_valid) quiet = 1'b0; end
    chk(quiet, "R10 disabled stays quiet", 64'(quiet), 64'd1);

    keys[0][1] = 1'b1; keys[2][7] = 1'b1; keys[15][0] = 1'b1;
    wmask[15*8 + 0] = 1'b0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++)
          run_cfg(rows_set[a], debs[b], gaps[c]);
    run_cfg(0, 1, 1);   // R1 zero rows reads as one
    run_cfg(31, 0, 0);  // R1 oversize clamps to 16

    run_cfg(1, 12'hFFF, 0);  // R4 saturation
    run_cfg(1, 12'h3FF, 0);  // R4 at limit
    run_cfg(1, 12'h3FE, 2);  // R4 below limit

    keys = '0; wmask = '1;
    keys[0][0] = 1; keys[0][3] = 1; keys[0][6] = 1; keys[1][2] = 1; keys[4][4] = 1; keys[4][5] = 1;
    keys[7][1] = 1; keys[9][0] = 1; keys[12][3] = 1; keys[14][7] = 1; keys[15][6] = 1;
    run_cfg(16, 1, 2);  // R7 overflow drops the last three

    keys = '0; keys[1][2] = 1'b1; chat_en = 1'b1; chr = 1; chc = 4;
    run_cfg(2, 3, 0);   // R5 chattering column rejected
    keys = '0;
    run_cfg(2, 1, 1);   // R5 chatter alone gives empty snapshot
    chat_en = 1'b0;

    keys[3][5] = 1'b1; wmask = '1;
    run_cfg(4, 0, 1);   // R9 all-ones mask row blocks
    wmask[3*8 + 4] = 1'b0;
    run_cfg(4, 0, 1);   // R9 neighbour bit open, key still blocked
    wmask = '1; wmask[3*8 + 5] = 1'b0;
    run_cfg(4, 0, 1);   // R9 last row key wakes on the strobe edge
    chk(wake == 1'b1, "R9 wake raised", 64'(wake), 64'd1);

    @(negedge clk); enable = 1'b0;
    repeat (2) @(negedge clk);
    chk(&row_drive && !snap_valid && !wake, "R10 drop of enable", {row_drive, wake}, 64'h1FFFE);
    quiet = 1'b1;
    repeat (300) begin @(negedge clk); if (!(&row_drive) || snap_valid) quiet = 1'b0; end
    chk(quiet, "R10 no scan while disabled", 64'(quiet), 64'd1);
    enable = 1'b1;
    wait_n = 0;
    while (wait_n < 20 && row_drive[0]) begin @(negedge clk); wait_n++; end
    chk(wait_n == 6, "R2 start wait after enable", 64'(wait_n), 64'd6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule